// File: doc/BRIEF.md
# Packing Bitwise Vector Unit

This unit executes the rare class of vector instructions that read SEW-wide source elements in runs of n and write each run as a single destination element SEW*n bits wide. Every SEW-sized slice of a wide destination element is the bitwise result (AND, OR, XOR, move or logical shift) of the matching SEW-level source elements. It lets software assemble a wide in-memory-style element from narrow ones in one instruction, without first gathering the pieces.

A start pulse latches both source register images, the old destination image, the per-element mask, vl, the operation, the aggregation code and the second-source form bit. The unit then writes one wide destination element per clock and ends with a one-cycle done strobe. vl counts SEW-level elements and must be a whole number of groups. An illegal combination raises a flag and leaves the destination as it was.

Top module: `pbv_unit`

## Requirements
- R1: The aggregation code c gives n = 2^c. A legal instruction makes G = vl/n groups, one per clock. `done` is high in the cycle after the G-th rising edge that follows the start edge, or in the cycle after the start edge when G = 0.
- R2: Op codes are 0 AND, 1 OR, 2 XOR and 3 move of the first source. Each applies per 8-bit slice, so for n = 1 it is the plain SEW-wide operation.
- R3: Op 4 is a logical left shift and op 5 a logical right shift. The shift amount is the low 3 bits of the second-source slice, and vacated bits are zero filled.
- R4: SEW element k lands in wide element k/n, slice k mod n, with slice 0 least significant. In the flat image, element k sits at bits [8k+7:8k] of both sources and of the destination.
- R5: Mask bit k governs SEW element k alone. A 0 keeps the old destination byte k, while the other slices of the same wide element are still written.
- R6: Destination bytes at element index vl and above keep their old value.
- R7: `src2_wide` = 0 reads the second source as n SEW elements. `src2_wide` = 1 reads it as one wide element cut into n slices. In the flat image both fetch the same bits, so the results are equal.
- R8: The instruction is illegal when vl is not a multiple of n, when n*SEW > VLEN (code 6 or 7), when vl > 32, or when the op is 6 or 7. `illegal` is then 1, the destination equals the old image, and G = 0.
- R9: `done` lasts one cycle. `illegal` holds its value until the next accepted start.
- R10: A start pulse while an instruction is running is ignored.
- R11: After reset, `vd_new`, `done` and `illegal` are 0. While idle and not started, `vd_new` holds its value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when idle |
| vs1 | input | 256 | First source register image |
| vs2 | input | 256 | Second source register image |
| vd_old | input | 256 | Old destination image |
| vmask | input | 32 | One mask bit per SEW element |
| vl | input | 6 | Count of SEW-level elements |
| op | input | 3 | Operation code |
| agg_code | input | 3 | log2 of the aggregation factor n |
| src2_wide | input | 1 | Second-source form select |
| vd_new | output | 256 | New destination image |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Illegal-combination flag |

## Verification
The bench builds the unit with its defaults: VLEN = 256 and SEW = 8, which gives 32 SEW lanes. With these values every aggregation code is reachable. Codes 0 to 5 give legal factors up to n = 32, where a single group fills the whole register. Codes 6 and 7 overflow VLEN, which exercises the illegal path. The small lane count also lets random vl values hit both exact multiples and near misses of n often.

// File: rtl/pbv_pkg.sv
package pbv_pkg;
    localparam int VLEN  = 256;
    localparam int SEW   = 8;
    localparam int CODEW = 3;
    localparam int NELEM = VLEN / SEW;
    localparam int IDXW  = $clog2(NELEM);
    localparam int VLW   = IDXW + 1;
    localparam int SHW   = $clog2(SEW);

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_XOR = 3'd2,
        OP_MOV = 3'd3,
        OP_SLL = 3'd4,
        OP_SRL = 3'd5
    } pbv_op_e;

    typedef logic [SEW-1:0] lane_t;

    typedef struct packed {
        logic           legal;
        logic [VLW-1:0] n;
    } agg_chk_t;

    function automatic lane_t lane_apply(logic [2:0] op, lane_t a, lane_t b);
        case (op)
            3'(OP_AND): return a & b;
            3'(OP_OR):  return a | b;
            3'(OP_XOR): return a ^ b;
            3'(OP_MOV): return a;
            3'(OP_SLL): return a << b[SHW-1:0];
            3'(OP_SRL): return a >> b[SHW-1:0];
            default:    return a;
        endcase
    endfunction

    function automatic agg_chk_t agg_check(logic [VLW-1:0] vl, logic [CODEW-1:0] code,
                                           logic [2:0] op);
        agg_chk_t r;
        int n;
        n = 1 << code;
        r.legal = (n <= NELEM) && (int'(vl) <= NELEM) && ((int'(vl) % n) == 0)
                  && (op <= 3'(OP_SRL));
        r.n = VLW'(n);
        return r;
    endfunction
endpackage

// File: rtl/pbv_lane_alu.sv
module pbv_lane_alu
    import pbv_pkg::*;
(
    input  logic [2:0] op,
    input  logic       src2_wide,
    input  lane_t      a,
    input  lane_t      b_sew,
    input  lane_t      b_wide,
    output lane_t      y
);
    lane_t b;
    assign b = src2_wide ? b_wide : b_sew;
    assign y = lane_apply(op, a, b);
endmodule

// File: rtl/pbv_ctrl.sv
module pbv_ctrl
    import pbv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VLW-1:0]   vl,
    input  logic [CODEW-1:0] agg_code,
    input  logic [2:0]       op,
    output logic             busy,
    output logic [VLW-1:0]   base,
    output logic [VLW-1:0]   n_q,
    output logic             done,
    output logic             illegal
);
    agg_chk_t       chk;
    logic [VLW-1:0] vl_q;
    logic [VLW-1:0] next_base;

    assign chk       = agg_check(vl, agg_code, op);
    assign next_base = base + n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            base    <= '0;
            n_q     <= '0;
            vl_q    <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                illegal <= !chk.legal;
                n_q     <= chk.n;
                vl_q    <= vl;
                base    <= '0;
                if (chk.legal && vl != '0) busy <= 1'b1;
                else                        done <= 1'b1;
            end else if (busy) begin
                base <= next_base;
                if (next_base == vl_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> !done);
    // R8
    illegal_idle_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !busy);
    // R1
    base_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (base < vl_q));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(vl_q) && $stable(n_q));
endmodule

// File: rtl/pbv_unit.sv
module pbv_unit
    import pbv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VLEN-1:0]  vs1,
    input  logic [VLEN-1:0]  vs2,
    input  logic [VLEN-1:0]  vd_old,
    input  logic [NELEM-1:0] vmask,
    input  logic [VLW-1:0]   vl,
    input  logic [2:0]       op,
    input  logic [CODEW-1:0] agg_code,
    input  logic             src2_wide,
    output logic [VLEN-1:0]  vd_new,
    output logic             done,
    output logic             illegal
);
    logic [VLEN-1:0]  vs1_q, vs2_q, vd_q, wide_img;
    logic [NELEM-1:0] mask_q, wr_en;
    logic [2:0]       op_q;
    logic             form_q, busy, accept;
    logic [VLW-1:0]   base, n_q;
    lane_t            lane_y [NELEM];

    assign accept = start && !busy;

    pbv_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .vl       (vl),
        .agg_code (agg_code),
        .op       (op),
        .busy     (busy),
        .base     (base),
        .n_q      (n_q),
        .done     (done),
        .illegal  (illegal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vs1_q  <= '0;
            vs2_q  <= '0;
            mask_q <= '0;
            op_q   <= '0;
            form_q <= 1'b0;
        end else if (accept) begin
            vs1_q  <= vs1;
            vs2_q  <= vs2;
            mask_q <= vmask;
            op_q   <= op;
            form_q <= src2_wide;
        end
    end

    // Current wide element of the second source, slice 0 at the bottom.
    assign wide_img = vs2_q >> (int'(base) * SEW);

    for (genvar k = 0; k < NELEM; k++) begin : g_lane
        logic [IDXW-1:0] slice_idx;
        logic            in_win;
        assign slice_idx = IDXW'(k) - base[IDXW-1:0];
        assign in_win    = busy && (VLW'(k) >= base) && (VLW'(k) < next_end);
        assign wr_en[k]  = in_win && mask_q[k];

        pbv_lane_alu u_alu (
            .op        (op_q),
            .src2_wide (form_q),
            .a         (vs1_q[k*SEW +: SEW]),
            .b_sew     (vs2_q[k*SEW +: SEW]),
            .b_wide    (wide_img[int'(slice_idx)*SEW +: SEW]),
            .y         (lane_y[k])
        );

        // R5
        masked_slice_chk: assert property (@(posedge clk) disable iff (rst)
            busy && !mask_q[k] |=> $stable(vd_q[k*SEW +: SEW]));
    end

    logic [VLW-1:0] next_end;
    assign next_end = base + n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vd_q <= '0;
        end else if (accept) begin
            vd_q <= vd_old;
        end else begin
            for (int k = 0; k < NELEM; k++) begin
                if (wr_en[k]) vd_q[k*SEW +: SEW] <= lane_y[k];
            end
        end
    end

    assign vd_new = vd_q;

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable(vd_q));
    // R8
    illegal_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        illegal && !start |=> $stable(vd_q));
endmodule

// File: tb/pbv_unit_bench.sv
module pbv_unit_bench;
    import pbv_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [VLEN-1:0]  vs1 = '0, vs2 = '0, vd_old = '0;
    logic [NELEM-1:0] vmask = '0;
    logic [VLW-1:0]   vl = '0;
    logic [2:0]       op = '0;
    logic [CODEW-1:0] agg_code = '0;
    logic             src2_wide = 1'b0;
    logic [VLEN-1:0]  vd_new;
    logic             done, illegal;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbv_unit u_pbv_unit (
        .clk(clk), .rst(rst), .start(start), .vs1(vs1), .vs2(vs2), .vd_old(vd_old),
        .vmask(vmask), .vl(vl), .op(op), .agg_code(agg_code), .src2_wide(src2_wide),
        .vd_new(vd_new), .done(done), .illegal(illegal)
    );

    function automatic bit ref_legal(int vlv, int code, int opv);
        int n = 1 << code;
        return (n * SEW <= VLEN) && (vlv <= NELEM) && (vlv % n == 0) && (opv <= 5);
    endfunction

    function automatic logic [7:0] ref_byte(int opv, logic [7:0] a, logic [7:0] b);
        case (opv)
            0: return a & b;
            1: return a | b;
            2: return a ^ b;
            3: return a;
            4: return a << b[2:0];
            default: return a >> b[2:0];
        endcase
    endfunction

    function automatic logic [VLEN-1:0] ref_image(logic [VLEN-1:0] a, logic [VLEN-1:0] b,
            logic [VLEN-1:0] old, logic [NELEM-1:0] m, int vlv, int code, int opv);
        logic [VLEN-1:0] r = old;
        if (!ref_legal(vlv, code, opv)) return r;
        for (int k = 0; k < vlv; k++)
            if (m[k]) r[k*8 +: 8] = ref_byte(opv, a[k*8 +: 8], b[k*8 +: 8]);
        return r;
    endfunction

    task automatic chk(string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(string req, logic [VLEN-1:0] a, logic [VLEN-1:0] b,
                       logic [VLEN-1:0] old, logic [NELEM-1:0] m, int vlv, int code,
                       int opv, bit form, bit poke);
        logic [VLEN-1:0] exp_img;
        int exp_g, cyc;
        bit lg;
        lg      = ref_legal(vlv, code, opv);
        exp_g   = lg ? vlv / (1 << code) : 0;
        exp_img = ref_image(a, b, old, m, vlv, code, opv);
        @(negedge clk);
        vs1 = a; vs2 = b; vd_old = old; vmask = m; vl = VLW'(vlv);
        agg_code = CODEW'(code); op = 3'(opv); src2_wide = form; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            if (poke && cyc == 0) begin start = 1'b1; vs1 = ~a; vd_old = ~old; end
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk({req, " R1 latency"}, VLEN'(cyc), VLEN'(exp_g));
        chk({req, " R8 illegal flag"}, VLEN'(illegal), VLEN'(!lg));
        chk({req, " image"}, vd_new, exp_img);
        @(negedge clk);
        // R9: done lasts one cycle, illegal holds
        chk({req, " R9 done pulse"}, VLEN'(done), VLEN'(0));
        chk({req, " R9 illegal held"}, VLEN'(illegal), VLEN'(!lg));
    endtask

    function automatic logic [VLEN-1:0] rnd_img();
        logic [VLEN-1:0] r;
        for (int i = 0; i < VLEN/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<150000", wd);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [VLEN-1:0] a, b, o, keep, r1, r2;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset vd_new", vd_new, '0);
        chk("R11 reset flags", VLEN'({done, illegal}), '0);

        a = rnd_img(); b = rnd_img(); o = rnd_img();
        run("R2 n1 and", a, b, o, '1, 32, 0, 0, 0, 0);
        run("R2 n2 or", a, b, o, '1, 16, 1, 1, 0, 0);
        run("R2 n4 xor", a, b, o, '1, 32, 2, 2, 0, 0);
        run("R2 n8 move", a, b, o, '1, 24, 3, 3, 0, 0);
        run("R3 sll n2", a, b, o, '1, 32, 1, 4, 0, 0);
        run("R3 srl n16", a, b, o, '1, 32, 4, 5, 1, 0);
        run("R4 n32 full", a, b, o, '1, 32, 5, 2, 1, 0);
        run("R5 sparse mask n4", a, b, o, 32'hA5C3_0F71, 32, 2, 1, 0, 0);
        run("R6 short vl n8", a, b, o, '1, 8, 3, 0, 0, 0);
        run("R6 vl zero", a, b, o, '1, 0, 0, 2, 0, 0);
        run("R8 vl not multiple", a, b, o, '1, 12, 3, 2, 0, 0);
        run("R8 n64 too wide", a, b, o, '1, 0, 6, 2, 0, 0);
        run("R8 n128 too wide", a, b, o, '1, 0, 7, 1, 0, 0);
        run("R8 bad op", a, b, o, '1, 8, 0, 6, 0, 0);
        run("R8 vl over 32", a, b, o, '1, 40, 0, 0, 0, 0);
        run("R10 start while busy", a, b, o, 32'h7FFF_FFFE, 32, 0, 2, 0, 1);

        // R7: both forms give the same image
        run("R7 form sew", a, b, o, 32'h3C3C_F00F, 32, 2, 2, 0, 0);
        r1 = vd_new;
        run("R7 form wide", a, b, o, 32'h3C3C_F00F, 32, 2, 2, 1, 0);
        r2 = vd_new;
        chk("R7 forms equal", r2, r1);

        // R11: idle hold while inputs change
        keep = vd_new;
        vs1 = rnd_img(); vd_old = rnd_img(); op = 3'd1;
        repeat (3) @(negedge clk);
        chk("R11 idle hold", vd_new, keep);

        for (int t = 0; t < 150; t++) begin
            int code, n, vlv, opv;
            code = $urandom_range(0, 5);
            n    = 1 << code;
            vlv  = n * $urandom_range(0, NELEM / n);
            if ($urandom_range(0, 9) == 0) vlv = $urandom_range(0, 33);
            opv  = ($urandom_range(0, 19) == 0) ? $urandom_range(6, 7) : $urandom_range(0, 5);
            run("R1 R2 R5 random", rnd_img(), rnd_img(), rnd_img(), NELEM'($urandom),
                vlv, code, opv, 1'($urandom), 1'($urandom_range(0, 3) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule